// File: doc/BRIEF.md
# Byte-to-Halfword Crosspoint Gearbox

The gearbox sits between a byte-wide link that delivers one byte on every fast clock cycle and a crosspoint datapath that is twice as wide and runs at half the rate. In the normal (paired) mode it gathers two consecutive bytes into a 16-bit word. The word is held in a staging register for a two-cycle crosspoint period and then loaded into a 16-bit output register. That register is sent out as two bytes on consecutive fast cycles, with the high byte first. Each byte may carry a signalling flag. In paired mode a flag can only travel with a high (even-phase) byte. A flag presented on an odd cycle is therefore held and attached to the next even-phase byte.

When the slow-clock control input is set, the pairing is bypassed. Each byte passes the input, staging and output registers on its own, one per cycle, and its flag stays with it. A change of the mode input flushes the pipeline and restarts the phase at even. The valid output stays low until the new mode's pipeline has filled.

The control is a three-state machine: `GBX_HI` (even phase, the high byte is being taken), `GBX_LO` (odd phase, the low byte completes the word) and `GBX_SOLO` (unpaired mode). The transitions are: `GBX_HI`→`GBX_LO` and `GBX_LO`→`GBX_HI` on every cycle in paired mode; `GBX_SOLO`→`GBX_SOLO` in unpaired mode; and a flush from any state to `GBX_HI` (mode input now 0) or to `GBX_SOLO` (mode input now 1) in any cycle where the mode input differs from the registered mode.

Top module: `bytewide_gearbox`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. While it is low and after its release, `out_valid` and `out_sig` stay low. Cycle 0 is the first cycle whose closing edge samples `rst_n` high, and it is an even (high-byte) phase.
- R2: With `slow_mode`=0, bytes presented in even cycle 2k and odd cycle 2k+1 (counted from cycle 0 or from a restart) appear on `out_byte` in cycles 2k+4 and 2k+5, in that order. The latency from first input byte to first output byte is four cycles.
- R3: In paired mode both bytes of a word are output with `out_valid`=1 in two adjacent cycles. The high byte comes in the even cycle and the low byte in the following odd cycle.
- R4: In paired mode, an `in_sig`=1 presented with an even-phase byte is output as `out_sig`=1 in the cycle that byte appears. `out_sig` is never 1 during a low-byte cycle.
- R5: In paired mode, an `in_sig`=1 presented with an odd-phase byte is not output with that byte. It is output with the next even-phase byte, merged (OR) with that byte's own flag.
- R6: With `slow_mode`=1, every byte presented in cycle c appears in cycle c+3 with `out_valid`=1, and its own `in_sig` value is on `out_sig`, whatever the cycle parity.
- R7: When `slow_mode` differs from the registered mode, the byte of that cycle is discarded and any held flag is dropped. Outputs not yet presented by that cycle are cancelled, and `out_valid` is 0 from the next cycle until the new mode's fill latency (R2 or R6) has passed. The next byte is an even-phase byte.
- R8: `out_sig` is 1 only while `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_mode | input | 1 | 1 = unpaired byte-at-a-time mode, 0 = paired mode |
| in_byte | input | LANE_W | Byte from the link, one per cycle |
| in_sig | input | 1 | Signalling flag for `in_byte` |
| out_byte | output | LANE_W | Byte toward the next stage |
| out_sig | output | 1 | Signalling flag for `out_byte` |
| out_valid | output | 1 | `out_byte` carries data |

## Verification
Two functions can fall in the same cycle. One is the odd-cycle flag hold of R5, which would normally ride on the next even byte. The other is a mode-change flush of R7, which must drop that held flag and cancel the half-finished word. The bench provokes this by raising `in_sig` on an odd byte and switching `slow_mode` in the very next cycle. Within the paired stream it also places an odd-cycle flag directly before an even-cycle flag, to exercise the merge. A scoreboard predicts every output cycle from the requirements. It judges that `out_valid` drops from the cycle after the switch, that no flag surfaces from the dropped hold, and that the first byte of the new mode arrives unflagged unless it carried its own flag.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    // Phase / mode states of the gearbox controller
    typedef enum logic [1:0] {
        GBX_HI   = 2'd0,  // paired mode, even phase: high byte taken
        GBX_LO   = 2'd1,  // paired mode, odd phase: low byte completes word
        GBX_SOLO = 2'd2   // unpaired mode: one byte per cycle
    } gbx_state_e;

endpackage

// File: rtl/gbx_phase_fsm.sv
module gbx_phase_fsm
    import gbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_mode,
    output gbx_state_e state,
    output logic       flush,
    output logic       xfer
);

    gbx_state_e state_q;
    gbx_state_e state_d;
    logic       mode_q;
    logic       mode_chg;

    // Next-state decision
    always_comb begin
        mode_chg = (slow_mode != mode_q);
        unique case (state_q)
            GBX_HI:   state_d = GBX_LO;
            GBX_LO:   state_d = GBX_HI;
            GBX_SOLO: state_d = GBX_SOLO;
            default:  state_d = GBX_HI;
        endcase
        if (mode_chg) begin
            state_d = slow_mode ? GBX_SOLO : GBX_HI;
        end
    end

    // State register (reset picks the mode seen during reset)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= slow_mode ? GBX_SOLO : GBX_HI;
            mode_q  <= slow_mode;
        end else begin
            state_q <= state_d;
            mode_q  <= slow_mode;
        end
    end

    // Outputs
    always_comb begin
        state = state_q;
        flush = mode_chg;
        xfer  = (state_q != GBX_HI) && !mode_chg;
    end

endmodule

// File: rtl/gbx_gather.sv
module gbx_gather
    import gbx_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gbx_state_e        state,
    input  logic              flush,
    input  logic [LANE_W-1:0] in_byte,
    input  logic              in_sig,
    output logic [WORD_W-1:0] word,
    output logic              word_sig,
    output logic              word_vld
);

    logic [LANE_W-1:0] hi_q;
    logic              hi_sig_q;
    logic              hi_vld_q;
    logic              pend_q;
    logic [WORD_W-1:0] word_q;
    logic              word_sig_q;
    logic              word_vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q       <= '0;
            hi_sig_q   <= 1'b0;
            hi_vld_q   <= 1'b0;
            pend_q     <= 1'b0;
            word_q     <= '0;
            word_sig_q <= 1'b0;
            word_vld_q <= 1'b0;
        end else if (flush) begin
            hi_vld_q   <= 1'b0;
            word_vld_q <= 1'b0;
            pend_q     <= 1'b0;
        end else begin
            unique case (state)
                GBX_HI: begin
                    hi_q     <= in_byte;
                    hi_sig_q <= in_sig | pend_q;
                    hi_vld_q <= 1'b1;
                    pend_q   <= 1'b0;
                end
                GBX_LO: begin
                    word_q     <= {hi_q, in_byte};
                    word_sig_q <= hi_sig_q;
                    word_vld_q <= hi_vld_q;
                    pend_q     <= in_sig;
                end
                GBX_SOLO: begin
                    hi_q       <= in_byte;
                    hi_sig_q   <= in_sig;
                    hi_vld_q   <= 1'b1;
                    word_q     <= {{LANE_W{1'b0}}, hi_q};
                    word_sig_q <= hi_sig_q;
                    word_vld_q <= hi_vld_q;
                    pend_q     <= 1'b0;
                end
                default: begin
                    hi_vld_q   <= 1'b0;
                    word_vld_q <= 1'b0;
                    pend_q     <= 1'b0;
                end
            endcase
        end
    end

    assign word     = word_q;
    assign word_sig = word_sig_q;
    assign word_vld = word_vld_q;

endmodule

// File: rtl/gbx_serialize.sv
module gbx_serialize
    import gbx_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gbx_state_e        state,
    input  logic              flush,
    input  logic              xfer,
    input  logic [WORD_W-1:0] word,
    input  logic              word_sig,
    input  logic              word_vld,
    output logic [LANE_W-1:0] out_byte,
    output logic              out_sig,
    output logic              out_valid
);

    logic [WORD_W-1:0] oreg_q;
    logic              osig_q;
    logic              ovld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oreg_q <= '0;
            osig_q <= 1'b0;
            ovld_q <= 1'b0;
        end else if (flush) begin
            ovld_q <= 1'b0;
        end else if (xfer) begin
            oreg_q <= word;
            osig_q <= word_sig;
            ovld_q <= word_vld;
        end
    end

    always_comb begin
        unique case (state)
            GBX_HI:   out_byte = oreg_q[WORD_W-1:LANE_W];
            GBX_LO:   out_byte = oreg_q[LANE_W-1:0];
            GBX_SOLO: out_byte = oreg_q[LANE_W-1:0];
            default:  out_byte = '0;
        endcase
        out_valid = ovld_q;
        out_sig   = ovld_q && osig_q && (state != GBX_LO);
    end

endmodule

// File: rtl/bytewide_gearbox.sv
module bytewide_gearbox
    import gbx_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_mode,
    input  logic [LANE_W-1:0] in_byte,
    input  logic              in_sig,
    output logic [LANE_W-1:0] out_byte,
    output logic              out_sig,
    output logic              out_valid
);

    gbx_state_e        state;
    logic              flush;
    logic              xfer;
    logic [WORD_W-1:0] word;
    logic              word_sig;
    logic              word_vld;

    gbx_phase_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_mode (slow_mode),
        .state     (state),
        .flush     (flush),
        .xfer      (xfer)
    );

    gbx_gather #(.LANE_W(LANE_W)) i_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .flush    (flush),
        .in_byte  (in_byte),
        .in_sig   (in_sig),
        .word     (word),
        .word_sig (word_sig),
        .word_vld (word_vld)
    );

    gbx_serialize #(.LANE_W(LANE_W)) i_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .flush     (flush),
        .xfer      (xfer),
        .word      (word),
        .word_sig  (word_sig),
        .word_vld  (word_vld),
        .out_byte  (out_byte),
        .out_sig   (out_sig),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/gbx_checker.sv
module gbx_checker
    import gbx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       slow_mode,
    input gbx_state_e state,
    input logic       flush,
    input logic       out_valid,
    input logic       out_sig
);

    AST_FLUSH_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R7

    AST_FLUSH_TO_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !slow_mode) |=> (state == GBX_HI)); // R7

    AST_HI_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GBX_HI && !flush) |=> (state == GBX_LO)); // R2

    AST_LO_TO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GBX_LO && !flush) |=> (state == GBX_HI)); // R2

    AST_PAIR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && state == GBX_HI && !flush) |=> out_valid); // R3

    AST_SIG_ONCE_PER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sig && state == GBX_HI) |=> !out_sig); // R4

    AST_SIG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_sig |-> out_valid); // R8

endmodule

bind bytewide_gearbox gbx_checker u_gbx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_mode (slow_mode),
    .state     (state),
    .flush     (flush),
    .out_valid (out_valid),
    .out_sig   (out_sig)
);

// File: tb/test_bytewide_gearbox.sv
`timescale 1ns/1ps
module test_bytewide_gearbox;

    localparam int LANE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              slow_mode = 1'b0;
    logic [LANE_W-1:0] in_byte = '0;
    logic              in_sig = 1'b0;
    logic [LANE_W-1:0] out_byte;
    logic              out_sig;
    logic              out_valid;

    always #2.5 clk = ~clk;

    bytewide_gearbox #(.LANE_W(LANE_W)) i_bytewide_gearbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_mode (slow_mode),
        .in_byte   (in_byte),
        .in_sig    (in_sig),
        .out_byte  (out_byte),
        .out_sig   (out_sig),
        .out_valid (out_valid)
    );

    typedef struct {
        int                due;
        logic [LANE_W-1:0] data;
        logic              sig;
        string             tag;
        string             sig_tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    int   errors = 0;
    int   checks = 0;
    int   cyc = -1;
    bit   done = 1'b0;
    bit   changed = 1'b0;
    logic cur_mode = 1'b0;
    int   ph = 0;
    logic pend = 1'b0;
    int   k = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, expv);
        end
    endtask

    // Driver: presents one byte per cycle and pushes the predicted output
    task automatic drive(input logic m, input logic s);
        exp_item_t it;
        logic [LANE_W-1:0] b;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        cyc++;
        k++;
        b = LANE_W'(k * 29 + 7);
        in_byte   = b;
        in_sig    = s;
        slow_mode = m;
        if (m != cur_mode) begin
            // R7: byte discarded, pending outputs beyond this cycle cancelled
            while (exp_q.size() > 0 && exp_q[$].due > cyc) void'(exp_q.pop_back());
            cur_mode = m;
            ph = 0;
            pend = 1'b0;
            changed = 1'b1;
            return;
        end
        if (m) begin
            it = '{cyc + 3, b, s, "R6", "R6"};
        end else if (ph == 0) begin
            it = '{cyc + 4, b, s | pend, "R2", (pend && !s) ? "R5" : "R4"};
            pend = 1'b0;
            ph = 1;
        end else begin
            it = '{cyc + 4, b, 1'b0, "R3", "R4"};
            pend = s;
            ph = 0;
        end
        exp_q.push_back(it);
    endtask

    // Monitor: compares outputs mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check(out_valid == 1'b0, "R1", int'(out_valid), 0);
            end else if (cyc >= 0) begin
                if (exp_q.size() > 0 && exp_q[0].due < cyc) begin
                    check(1'b0, exp_q[0].tag, cyc, exp_q[0].due);
                    void'(exp_q.pop_front());
                end
                if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                    check(out_valid == 1'b1, exp_q[0].tag, int'(out_valid), 1);
                    check(out_byte == exp_q[0].data, exp_q[0].tag, int'(out_byte), int'(exp_q[0].data));
                    check(out_sig == exp_q[0].sig, exp_q[0].sig_tag, int'(out_sig), int'(exp_q[0].sig));
                    void'(exp_q.pop_front());
                end else begin
                    check(out_valid == 1'b0, changed ? "R7" : "R1", int'(out_valid), 0);
                    check(out_sig == 1'b0, "R8", int'(out_sig), 0);
                end
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        // Paired mode: flags on even 2, odd 5, odd 9 + even 10, odd 17, odd 23
        for (int i = 0; i < 24; i++) begin
            drive(1'b0, (i == 2) || (i == 5) || (i == 9) || (i == 10) || (i == 17) || (i == 23));
        end
        // Switch right after an odd flag: held flag must vanish (R5 vs R7)
        drive(1'b1, 1'b1);
        for (int i = 0; i < 20; i++) drive(1'b1, (i % 3) == 1);
        // Back to paired mode, flag on the discarded byte
        drive(1'b0, 1'b1);
        for (int i = 0; i < 30; i++) drive(1'b0, (i % 5) == 2);
        // Two flushes back to back
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
        for (int i = 0; i < 20; i++) drive(1'b0, (i % 4) == 1);
        // Switch on an odd cycle after an even byte to cut a word in half
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        for (int i = 0; i < 12; i++) drive(1'b1, i[0]);
        @(posedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule